// File: doc/BRIEF.md
# Rectangle Fill and Vertical Scroll Engine

This block is the drawing engine of a 32-bit-per-pixel frame buffer. Software programs a small set of registers through a one-word write port: a draw opcode, a raster operation, a foreground colour, a plane mask, two corner coordinates and the height and width of the area. The width write launches the operation. The engine then walks the area one pixel at a time and sends read and write requests to a simple pixel memory port, holding `busy` high until the final pixel write has been issued.

Two operations exist. A rectangle fill paints an area with the foreground colour under one of three raster operations. A vertical block copy moves an area to another row range in the same column range, as a scroll does. When the two areas overlap, the row order is chosen so that no source row is overwritten before it has been read. Every pixel write carries the plane mask as a per-bit write enable, so memory bits whose mask bit is zero keep their value.

Pixel byte address is `y * 8192 + x * 4`. The colour word holds blue in bits 23:16, green in 15:8 and red in 7:0. The engine passes this word through unchanged.

Top module: `fill_scroll_engine`

## Requirements
- R1: After reset `busy`, `memRd` and `memWr` are 0, `regWrReady` is 1 and `memWmask` is 0xFFFFFFFF. The raster op resets to 0x83.
- R2: A register write is accepted on a clock edge with `regWrValid` and `regWrReady` both high. Select codes are 0 opcode, 1 raster op, 2 colour, 3 plane mask, 4 base y, 5 base x, 6 destination y, 7 destination x, 8 height, 9 width. Only an accepted width write starts an operation. Writes to the other codes leave `busy` low and issue no memory request.
- R3: Opcode 0x08 fills the area that starts at (base y, base x). Rows go top to bottom and columns left to right. Each pixel goes to byte address y*8192 + x*4. With raster op 0x83 every pixel is a single write of the colour, one per cycle, and no reads are made.
- R4: Under fill, raster op 0x85 keeps the old pixel and 0x86 writes colour XOR old pixel. In both cases each pixel is a read followed in the next cycle by the write. `memRdata` is taken one cycle after its read. Any other raster op code acts as 0x83.
- R5: Every pixel write presents the plane-mask register on `memWmask`.
- R6: Opcode 0x0B reads the pixel at (base y + r, base x + c) and writes that value, in the next cycle, to (destination y + r, destination x + c). The raster op and the colour have no effect.
- R7: For opcode 0x0B, if destination y is greater than base y the rows are processed from the bottom row upward. Otherwise they are processed from the top row downward. The result equals a copy of the whole source area taken before any write.
- R8: Opcode 0x0B with base x unequal to destination x, or with base y equal to destination y, issues no memory request. An opcode other than 0x08 or 0x0B does the same. In all these cases `busy` is high for exactly one cycle.
- R9: A zero height or a zero width issues no memory request, and `busy` is high for one cycle.
- R10: `busy` rises in the cycle after the accepted width write and falls in the cycle after the last pixel write. `regWrReady` is low while `busy` is high. A write held pending during an operation is accepted in the first cycle `busy` is low, and it does not affect the operation in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrValid | input | 1 | Register write request |
| regWrReady | output | 1 | Register write can be accepted this cycle |
| regWrSel | input | 4 | Register select code |
| regWrData | input | 32 | Register write data |
| busy | output | 1 | Operation in progress |
| memRd | output | 1 | Pixel read request |
| memWr | output | 1 | Pixel write request |
| memAddr | output | 25 | Pixel byte address |
| memWdata | output | 32 | Pixel write data |
| memWmask | output | 32 | Per-bit write enable |
| memRdata | input | 32 | Read data, valid one cycle after the read |

## Verification
Two things can land on the same cycle: the final pixel write of an operation and a register write that has been waiting with valid held high. The bench provokes this by starting a fill and presenting a colour write at once. It then counts the stalled cycles, which must equal the launch cycle plus one per pixel write. It also checks that the filled pixels carry the old colour rather than the new one. The two overlapping scroll directions are judged by comparing memory against a copy of the source that the bench takes before any write. A smear from the wrong row order would show up in that comparison.

// File: rtl/fillscroll_pkg.sv
package fillscroll_pkg;

  typedef enum logic [3:0] {
    SEL_OPCODE = 4'd0,
    SEL_ROP    = 4'd1,
    SEL_COLOUR = 4'd2,
    SEL_PMASK  = 4'd3,
    SEL_BASE_Y = 4'd4,
    SEL_BASE_X = 4'd5,
    SEL_DEST_Y = 4'd6,
    SEL_DEST_X = 4'd7,
    SEL_HEIGHT = 4'd8,
    SEL_WIDTH  = 4'd9
  } regSel_e;

  localparam logic [31:0] OP_FILL   = 32'h08;
  localparam logic [31:0] OP_SCROLL = 32'h0B;
  localparam logic [31:0] ROP_NEW   = 32'h83;
  localparam logic [31:0] ROP_OLD   = 32'h85;
  localparam logic [31:0] ROP_XOR   = 32'h86;

  // strobes from control to datapath
  typedef struct packed {
    logic clr;
    logic advance;
    logic rdPhase;
    logic wrPhase;
  } ctrl_t;

  // status from datapath to control
  typedef struct packed {
    logic launchOk;
    logic needRead;
    logic lastPix;
  } stat_t;

endpackage

// File: rtl/fse_ctrl.sv
module fse_ctrl
  import fillscroll_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       regWrValid,
  input  logic [3:0] regWrSel,
  input  stat_t      stat,
  output ctrl_t      ctrl,
  output logic       regWrReady,
  output logic       busy,
  output logic       memRd,
  output logic       memWr
);

  typedef enum logic [1:0] {ST_IDLE, ST_LAUNCH, ST_READ, ST_WRITE} state_e;

  state_e state, stateNxt;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNxt;
  end

  always_comb begin
    stateNxt = state;
    unique case (state)
      ST_IDLE:   if (regWrValid && regWrSel == SEL_WIDTH) stateNxt = ST_LAUNCH;
      ST_LAUNCH: if (!stat.launchOk)  stateNxt = ST_IDLE;
                 else if (stat.needRead) stateNxt = ST_READ;
                 else                 stateNxt = ST_WRITE;
      ST_READ:   stateNxt = ST_WRITE;
      ST_WRITE:  if (stat.lastPix)    stateNxt = ST_IDLE;
                 else if (stat.needRead) stateNxt = ST_READ;
                 else                 stateNxt = ST_WRITE;
      default:   stateNxt = ST_IDLE;
    endcase
  end

  assign regWrReady   = (state == ST_IDLE);
  assign busy         = (state != ST_IDLE);
  assign ctrl.clr     = (state == ST_LAUNCH);
  assign ctrl.advance = (state == ST_WRITE);
  assign ctrl.rdPhase = (state == ST_READ);
  assign ctrl.wrPhase = (state == ST_WRITE);
  assign memRd        = ctrl.rdPhase;
  assign memWr        = ctrl.wrPhase;

endmodule

// File: rtl/fse_datapath.sv
module fse_datapath
  import fillscroll_pkg::*;
#(
  parameter int Y_W     = 12,
  parameter int X_W     = 11,
  parameter int LINE_SH = 13,
  parameter int PIX_SH  = 2,
  parameter int ADDR_W  = Y_W + LINE_SH
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [3:0]        regWrSel,
  input  logic [31:0]       regWrData,
  input  ctrl_t             ctrl,
  input  logic [31:0]       memRdata,
  output stat_t             stat,
  output logic [ADDR_W-1:0] memAddr,
  output logic [31:0]       memWdata,
  output logic [31:0]       memWmask
);

  logic [31:0]    opcode, rop, colour, planeMask;
  logic [Y_W-1:0] baseY, destY, height, rowIdx, effRow, rdY, wrY;
  logic [X_W-1:0] baseX, destX, width, colIdx, rdX, wrX;
  logic           isFill, isScroll, bottomUp, lastCol;
  logic           unusedHiBits;

  assign unusedHiBits = ^regWrData[31:Y_W];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      opcode    <= '0;
      rop       <= ROP_NEW;
      colour    <= '0;
      planeMask <= '1;
      baseY     <= '0;
      baseX     <= '0;
      destY     <= '0;
      destX     <= '0;
      height    <= '0;
      width     <= '0;
    end else if (regWe) begin
      case (regWrSel)
        SEL_OPCODE: opcode    <= regWrData;
        SEL_ROP:    rop       <= regWrData;
        SEL_COLOUR: colour    <= regWrData;
        SEL_PMASK:  planeMask <= regWrData;
        SEL_BASE_Y: baseY     <= regWrData[Y_W-1:0];
        SEL_BASE_X: baseX     <= regWrData[X_W-1:0];
        SEL_DEST_Y: destY     <= regWrData[Y_W-1:0];
        SEL_DEST_X: destX     <= regWrData[X_W-1:0];
        SEL_HEIGHT: height    <= regWrData[Y_W-1:0];
        SEL_WIDTH:  width     <= regWrData[X_W-1:0];
        default: ;
      endcase
    end
  end

  // pixel walk: column inner, row outer
  assign lastCol = (colIdx == width - X_W'(1));

  always_ff @(posedge clk) begin
    if (!rstN || ctrl.clr) begin
      rowIdx <= '0;
      colIdx <= '0;
    end else if (ctrl.advance) begin
      if (lastCol) begin
        colIdx <= '0;
        rowIdx <= rowIdx + Y_W'(1);
      end else begin
        colIdx <= colIdx + X_W'(1);
      end
    end
  end

  assign isFill   = (opcode == OP_FILL);
  assign isScroll = (opcode == OP_SCROLL);
  assign bottomUp = isScroll && (destY > baseY);
  assign effRow   = bottomUp ? (height - Y_W'(1) - rowIdx) : rowIdx;

  assign stat.launchOk = (height != '0) && (width != '0) &&
                         (isFill || (isScroll && destX == baseX && destY != baseY));
  assign stat.needRead = isScroll || rop == ROP_OLD || rop == ROP_XOR;
  assign stat.lastPix  = lastCol && (rowIdx == height - Y_W'(1));

  function automatic logic [ADDR_W-1:0] pixAddr(input logic [Y_W-1:0] y,
                                                input logic [X_W-1:0] x);
    return {y, {LINE_SH{1'b0}}} +
           {{(ADDR_W-X_W-PIX_SH){1'b0}}, x, {PIX_SH{1'b0}}};
  endfunction

  assign rdY = baseY + effRow;
  assign rdX = baseX + colIdx;
  assign wrY = isScroll ? destY + effRow : rdY;
  assign wrX = isScroll ? destX + colIdx : rdX;

  assign memAddr  = ctrl.wrPhase ? pixAddr(wrY, wrX) : pixAddr(rdY, rdX);
  assign memWmask = planeMask;

  always_comb begin
    if (isScroll || rop == ROP_OLD) memWdata = memRdata;
    else if (rop == ROP_XOR)        memWdata = colour ^ memRdata;
    else                            memWdata = colour;
  end

endmodule

// File: rtl/fill_scroll_engine.sv
module fill_scroll_engine
  import fillscroll_pkg::*;
#(
  parameter int Y_W        = 12,
  parameter int X_W        = 11,
  parameter int LINE_BYTES = 8192,
  parameter int PIX_BYTES  = 4,
  localparam int LINE_SH   = $clog2(LINE_BYTES),
  localparam int PIX_SH    = $clog2(PIX_BYTES),
  localparam int ADDR_W    = Y_W + LINE_SH
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrValid,
  output logic              regWrReady,
  input  logic [3:0]        regWrSel,
  input  logic [31:0]       regWrData,
  output logic              busy,
  output logic              memRd,
  output logic              memWr,
  output logic [ADDR_W-1:0] memAddr,
  output logic [31:0]       memWdata,
  output logic [31:0]       memWmask,
  input  logic [31:0]       memRdata
);

  ctrl_t ctrl;
  stat_t stat;

  fse_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .regWrValid(regWrValid), .regWrSel(regWrSel),
    .stat(stat), .ctrl(ctrl), .regWrReady(regWrReady), .busy(busy),
    .memRd(memRd), .memWr(memWr)
  );

  fse_datapath #(
    .Y_W(Y_W), .X_W(X_W), .LINE_SH(LINE_SH), .PIX_SH(PIX_SH), .ADDR_W(ADDR_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .regWe(regWrValid && regWrReady),
    .regWrSel(regWrSel), .regWrData(regWrData), .ctrl(ctrl),
    .memRdata(memRdata), .stat(stat), .memAddr(memAddr),
    .memWdata(memWdata), .memWmask(memWmask)
  );

endmodule

// File: rtl/fse_checker.sv
module fse_checker (
  input logic        clk,
  input logic        rstN,
  input logic        regWrValid,
  input logic        regWrReady,
  input logic        busy,
  input logic        memRd,
  input logic        memWr,
  input logic [31:0] memWmask
);

  AST_RD_WR_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(memRd && memWr)); // R4

  AST_RD_THEN_WR: assert property (@(posedge clk) disable iff (!rstN)
    memRd |=> memWr); // R4

  AST_QUIET_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !(memRd || memWr)); // R10

  AST_START_ON_ACCEPT: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(regWrValid && regWrReady)); // R2

  AST_MASK_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |-> $stable(memWmask)); // R5

endmodule

bind fill_scroll_engine fse_checker u_fseChk (
  .clk(clk), .rstN(rstN), .regWrValid(regWrValid), .regWrReady(regWrReady),
  .busy(busy), .memRd(memRd), .memWr(memWr), .memWmask(memWmask)
);

// File: tb/fill_scroll_engine_bench.sv
module fill_scroll_engine_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrValid = 1'b0;
  logic        regWrReady;
  logic [3:0]  regWrSel = '0;
  logic [31:0] regWrData = '0;
  logic        busy, memRd, memWr;
  logic [24:0] memAddr;
  logic [31:0] memWdata, memWmask, memRdata;

  always #4 clk = ~clk; // 125 MHz

  fill_scroll_engine u_fill_scroll_engine (.*);

  int checks = 0, errors = 0;
  logic [31:0] mem [int];
  logic [31:0] expm [int];
  int wrLog[$];
  int nRd = 0, nWr = 0, maskBad = 0, lastStalls = 0;
  logic [31:0] maskExp = 32'hFFFF_FFFF;
  logic [31:0] rdBuf = '0;
  assign memRdata = rdBuf;

  function automatic int pa(int y, int x);
    return y * 8192 + x * 4;
  endfunction

  function automatic logic [31:0] rdm(int a);
    return mem.exists(a) ? mem[a] : 32'h0;
  endfunction

  function automatic logic [31:0] rde(int a);
    return expm.exists(a) ? expm[a] : 32'h0;
  endfunction

  // pixel memory with one-cycle read latency and per-bit write enable
  always @(posedge clk) begin : memModel
    int a;
    if (memRd) begin
      rdBuf <= rdm(int'(memAddr));
      nRd++;
    end
    if (memWr) begin
      a = int'(memAddr);
      mem[a] = (memWdata & memWmask) | (rdm(a) & ~memWmask);
      wrLog.push_back(a);
      nWr++;
      if (memWmask !== maskExp) maskBad++;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] sel, input logic [31:0] d);
    int stalls = 0;
    logic acc = 1'b0;
    regWrValid = 1'b1; regWrSel = sel; regWrData = d;
    while (!acc) begin
      acc = regWrReady;
      if (!acc) stalls++;
      @(negedge clk);
    end
    regWrValid = 1'b0;
    lastStalls = stalls;
  endtask

  task automatic waitIdle(output int n);
    n = 0;
    while (busy && n < 5000) begin n++; @(negedge clk); end
  endtask

  task automatic clearLog();
    wrLog.delete(); nRd = 0; nWr = 0; maskBad = 0;
  endtask

  task automatic preload(int y0, int x0, int h, int w, logic [31:0] seed);
    for (int y = y0 - 1; y <= y0 + h; y++)
      for (int x = x0 - 1; x <= x0 + w; x++)
        mem[pa(y, x)] = seed ^ (32'(y) << 16) ^ 32'(x * 7);
    expm = mem;
  endtask

  task automatic fillModel(int y0, int x0, int h, int w, logic [31:0] rop,
                           logic [31:0] fg, logic [31:0] mask);
    for (int y = y0; y < y0 + h; y++)
      for (int x = x0; x < x0 + w; x++) begin
        logic [31:0] o, n;
        o = rde(pa(y, x));
        n = (rop == 32'h85) ? o : (rop == 32'h86) ? (fg ^ o) : fg;
        expm[pa(y, x)] = (n & mask) | (o & ~mask);
      end
  endtask

  task automatic scrollModel(int sy, int x0, int dy, int h, int w, logic [31:0] mask);
    logic [31:0] tmp [int];
    for (int r = 0; r < h; r++)
      for (int c = 0; c < w; c++) tmp[r * 64 + c] = rde(pa(sy + r, x0 + c));
    for (int r = 0; r < h; r++)
      for (int c = 0; c < w; c++) begin
        logic [31:0] o;
        o = rde(pa(dy + r, x0 + c));
        expm[pa(dy + r, x0 + c)] = (tmp[r * 64 + c] & mask) | (o & ~mask);
      end
  endtask

  task automatic cmpRegion(string req, int y0, int x0, int h, int w);
    int bad = 0;
    for (int y = y0 - 1; y <= y0 + h; y++)
      for (int x = x0 - 1; x <= x0 + w; x++)
        if (rdm(pa(y, x)) !== rde(pa(y, x))) bad++;
    chk({req, " region mismatches"}, 32'(bad), 32'd0);
  endtask

  task automatic startFill(int y, int x, int h, int w);
    wr(4'd0, 32'h08); wr(4'd4, 32'(y)); wr(4'd5, 32'(x));
    wr(4'd8, 32'(h)); clearLog(); wr(4'd9, 32'(w));
  endtask

  task automatic startScroll(int sy, int sx, int dy, int dx, int h, int w);
    wr(4'd0, 32'h0B); wr(4'd4, 32'(sy)); wr(4'd5, 32'(sx));
    wr(4'd6, 32'(dy)); wr(4'd7, 32'(dx)); wr(4'd8, 32'(h));
    clearLog(); wr(4'd9, 32'(w));
  endtask

  task automatic tReset();
    chk("R1 busy", {31'd0, busy}, 32'd0);
    chk("R1 ready", {31'd0, regWrReady}, 32'd1);
    chk("R1 requests", {30'd0, memRd, memWr}, 32'd0);
    chk("R1 mask", memWmask, 32'hFFFF_FFFF);
  endtask

  task automatic tNoStart();
    clearLog();
    wr(4'd0, 32'h08); wr(4'd8, 32'd2); wr(4'd2, 32'h0011_2233);
    @(negedge clk);
    chk("R2 no start busy", {31'd0, busy}, 32'd0);
    chk("R2 no start requests", 32'(nRd + nWr), 32'd0);
  endtask

  task automatic tFillNew();
    int n;
    preload(5, 10, 3, 4, 32'hA5A5_0000);
    wr(4'd1, 32'h83); wr(4'd2, 32'h00C0_FFEE);
    fillModel(5, 10, 3, 4, 32'h83, 32'h00C0_FFEE, 32'hFFFF_FFFF);
    startFill(5, 10, 3, 4);
    waitIdle(n);
    chk("R10 busy cycles fill", 32'(n), 32'd13);
    chk("R3 reads", 32'(nRd), 32'd0);
    chk("R3 writes", 32'(nWr), 32'd12);
    chk("R3 first addr", 32'(wrLog[0]), 32'(pa(5, 10)));
    chk("R3 second addr", 32'(wrLog[1]), 32'(pa(5, 11)));
    chk("R3 row step addr", 32'(wrLog[4]), 32'(pa(6, 10)));
    chk("R3 last addr", 32'(wrLog[11]), 32'(pa(7, 13)));
    cmpRegion("R3", 5, 10, 3, 4);
  endtask

  task automatic tFillXorMask();
    int n;
    preload(50, 100, 2, 3, 32'h1234_5678);
    maskExp = 32'h00FF_00FF;
    wr(4'd3, maskExp); wr(4'd1, 32'h86); wr(4'd2, 32'h00F0_F00F);
    fillModel(50, 100, 2, 3, 32'h86, 32'h00F0_F00F, maskExp);
    startFill(50, 100, 2, 3);
    waitIdle(n);
    chk("R4 xor busy cycles", 32'(n), 32'd13);
    chk("R4 xor reads", 32'(nRd), 32'd6);
    chk("R5 mask on writes", 32'(maskBad), 32'd0);
    cmpRegion("R4 R5 xor", 50, 100, 2, 3);
    maskExp = 32'hFFFF_FFFF;
    wr(4'd3, maskExp);
  endtask

  task automatic tFillOld();
    int n;
    preload(60, 20, 2, 2, 32'h0BAD_F00D);
    wr(4'd1, 32'h85); wr(4'd2, 32'h00FF_FFFF);
    startFill(60, 20, 2, 2);
    waitIdle(n);
    chk("R4 old writes", 32'(nWr), 32'd4);
    chk("R4 old reads", 32'(nRd), 32'd4);
    cmpRegion("R4 old unchanged", 60, 20, 2, 2);
  endtask

  task automatic tFillOtherRop();
    int n;
    preload(70, 30, 1, 3, 32'h5555_0000);
    wr(4'd1, 32'h00); wr(4'd2, 32'h0001_0203);
    fillModel(70, 30, 1, 3, 32'h83, 32'h0001_0203, 32'hFFFF_FFFF);
    startFill(70, 30, 1, 3);
    waitIdle(n);
    chk("R4 other rop reads", 32'(nRd), 32'd0);
    cmpRegion("R4 other rop", 70, 30, 1, 3);
  endtask

  task automatic tScrollUp();
    int n;
    preload(38, 2, 6, 3, 32'h7700_0000);
    wr(4'd1, 32'h86);
    scrollModel(40, 2, 38, 3, 3, 32'hFFFF_FFFF);
    startScroll(40, 2, 38, 2, 3, 3);
    waitIdle(n);
    chk("R10 scroll busy cycles", 32'(n), 32'd19);
    chk("R7 up first write", 32'(wrLog[0]), 32'(pa(38, 2)));
    chk("R6 up reads", 32'(nRd), 32'd9);
    cmpRegion("R6 R7 up", 38, 2, 6, 3);
  endtask

  task automatic tScrollDown();
    int n;
    preload(30, 7, 4, 2, 32'h0066_6600);
    maskExp = 32'hFFFF_0000;
    wr(4'd3, maskExp); wr(4'd1, 32'h85);
    scrollModel(30, 7, 31, 3, 2, maskExp);
    startScroll(30, 7, 31, 7, 3, 2);
    waitIdle(n);
    chk("R7 down first write", 32'(wrLog[0]), 32'(pa(33, 7)));
    chk("R7 down last write", 32'(wrLog[5]), 32'(pa(31, 8)));
    cmpRegion("R6 R7 down", 30, 7, 4, 2);
    maskExp = 32'hFFFF_FFFF;
    wr(4'd3, maskExp);
  endtask

  task automatic tInvalid();
    int n;
    startScroll(10, 5, 20, 6, 2, 2);
    waitIdle(n);
    chk("R8 x differ busy", 32'(n), 32'd1);
    chk("R8 x differ requests", 32'(nRd + nWr), 32'd0);
    startScroll(10, 5, 10, 5, 2, 2);
    waitIdle(n);
    chk("R8 same y requests", 32'(nRd + nWr), 32'd0);
    wr(4'd0, 32'h01); clearLog(); wr(4'd9, 32'd4);
    waitIdle(n);
    chk("R8 bad opcode busy", 32'(n), 32'd1);
    chk("R8 bad opcode requests", 32'(nRd + nWr), 32'd0);
  endtask

  task automatic tZero();
    int n;
    startFill(3, 3, 2, 0);
    waitIdle(n);
    chk("R9 zero width busy", 32'(n), 32'd1);
    chk("R9 zero width requests", 32'(nRd + nWr), 32'd0);
    startFill(3, 3, 0, 5);
    waitIdle(n);
    chk("R9 zero height requests", 32'(nRd + nWr), 32'd0);
  endtask

  task automatic tStall();
    int n;
    preload(90, 40, 2, 2, 32'h3030_0000);
    wr(4'd1, 32'h83); wr(4'd2, 32'h00AB_CDEF);
    fillModel(90, 40, 2, 2, 32'h83, 32'h00AB_CDEF, 32'hFFFF_FFFF);
    startFill(90, 40, 2, 2);
    wr(4'd2, 32'h0012_3456);
    chk("R10 stall cycles", 32'(lastStalls), 32'd5);
    chk("R10 busy after accept", {31'd0, busy}, 32'd0);
    cmpRegion("R10 held write no effect", 90, 40, 2, 2);
    waitIdle(n);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    tReset();
    tNoStart();
    tFillNew();
    tFillXorMask();
    tFillOld();
    tFillOtherRop();
    tScrollUp();
    tScrollDown();
    tInvalid();
    tZero();
    tStall();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule